// File: doc/BRIEF.md
# Target Event Enable Control

This block sits inside an I3C target and acts on the two common commands that let the bus controller permit or forbid target-initiated traffic. An upstream command decoder hands over, with a one-cycle strobe, the command code and the defining byte that followed it. With them come a flag that tells broadcast from direct delivery and a flag that says whether a direct address phase selected this target for a write. The block keeps the in-band interrupt enable and the hot-join enable in a small event-control register. It also shows a controller-role enable bit that is permanently zero.

Two commands act on the register. One sets the bits whose byte positions are 1, and the other clears them. Each command exists in a broadcast code and a direct code. A 0 in the byte leaves its bit untouched. The controller-role position and the reserved positions are discarded.

The target's own request logic raises `ibi_req` or `hj_req`. The block passes each request on through `ibi_go` or `hj_go` only while the matching enable is set, so a disabled request can never begin on the bus.

Top module: `evt_enable_ctl`

## Requirements
- R1: After reset the in-band interrupt enable and the hot-join enable are 1 and the controller-role enable is 0, so `evt_ctl` reads 8'h09.
- R2: An accepted enable command with byte bit 0 set makes `ibi_en` 1 on the next clock. An accepted disable command with byte bit 0 set makes it 0 on the next clock.
- R3: An accepted enable command with byte bit 3 set makes `hj_en` 1 on the next clock. An accepted disable command with byte bit 3 set makes it 0 on the next clock.
- R4: A byte bit that is 0 leaves its enable unchanged. Byte bit 2 and bits 7 to 4 are reserved and have no effect.
- R5: Byte bit 1 (controller role) has no effect in either command. `cr_en` and `evt_ctl[1]` are always 0.
- R6: Code 8'h00 is broadcast enable, 8'h01 broadcast disable, 8'h80 direct enable and 8'h81 direct disable. Any other code leaves the register unchanged.
- R7: A direct code is applied only when `ccc_dir_hit` is 1. A broadcast code is applied whatever `ccc_dir_hit` is.
- R8: A code is applied only when `ccc_bcast` agrees with its form: 1 for 8'h00/8'h01 and 0 for 8'h80/8'h81. A mismatch is ignored.
- R9: `ibi_go` equals `ibi_req` while `ibi_en` is 1 and is 0 otherwise. `hj_go` behaves the same way with `hj_req` and `hj_en`.
- R10: Without `ccc_valid` the register holds its value, whatever the other command inputs carry.
- R11: `evt_ctl` holds the in-band interrupt enable in bit 0, the controller-role enable in bit 1 and the hot-join enable in bit 3. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ccc_valid | input | 1 | One-cycle strobe: command code and defining byte are valid |
| ccc_code | input | 8 | Common command code |
| ccc_bcast | input | 1 | 1 for broadcast delivery, 0 for direct |
| ccc_dir_hit | input | 1 | Direct address phase matched this target with a write |
| ccc_data | input | 8 | Defining byte of the command |
| ibi_req | input | 1 | In-band interrupt request from the target's request logic |
| hj_req | input | 1 | Hot-join request from the target's request logic |
| ibi_en | output | 1 | In-band interrupt enable |
| hj_en | output | 1 | Hot-join enable |
| cr_en | output | 1 | Controller-role enable, constant 0 |
| evt_ctl | output | 8 | Event-control register view |
| ibi_go | output | 1 | Gated in-band interrupt request |
| hj_go | output | 1 | Gated hot-join request |

## Verification
Directed sequences first set and clear each enable alone through both the broadcast and the direct codes. This separates the per-bit update paths from a design that writes the whole byte. Commands that should be ignored are then sent: direct codes without an address hit, a form flag that disagrees with the code, neighbouring codes, reserved-only and controller-role-only bytes, and full command inputs held with the strobe low. Each of these must leave the register as it was, and the only way to see that is to hold a known non-reset state first. A long random stream of mixed valid and invalid commands, with the request inputs toggling, is then checked every clock against a behavioural model. That stream catches ordering effects and gating errors that the directed cases miss.

// File: rtl/evt_enable_ctl.sv
`timescale 1ns/1ps
module evt_enable_ctl #(
  parameter logic [7:0] BC_ENABLE   = 8'h00,
  parameter logic [7:0] BC_DISABLE  = 8'h01,
  parameter logic [7:0] DIR_ENABLE  = 8'h80,
  parameter logic [7:0] DIR_DISABLE = 8'h81,
  parameter int         IBI_BIT     = 0,
  parameter int         CR_BIT      = 1,
  parameter int         HJ_BIT      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ccc_valid,
  input  logic [7:0] ccc_code,
  input  logic       ccc_bcast,
  input  logic       ccc_dir_hit,
  input  logic [7:0] ccc_data,
  input  logic       ibi_req,
  input  logic       hj_req,
  output logic       ibi_en,
  output logic       hj_en,
  output logic       cr_en,
  output logic [7:0] evt_ctl,
  output logic       ibi_go,
  output logic       hj_go
);

  logic ibi_q, hj_q;
  logic do_set, do_clr;

  assign do_set = ccc_valid &&
                  ((ccc_code == BC_ENABLE  &&  ccc_bcast) ||
                   (ccc_code == DIR_ENABLE && !ccc_bcast && ccc_dir_hit));
  assign do_clr = ccc_valid &&
                  ((ccc_code == BC_DISABLE  &&  ccc_bcast) ||
                   (ccc_code == DIR_DISABLE && !ccc_bcast && ccc_dir_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibi_q <= 1'b1;
      hj_q  <= 1'b1;
    end else if (do_set) begin
      if (ccc_data[IBI_BIT]) ibi_q <= 1'b1;
      if (ccc_data[HJ_BIT])  hj_q  <= 1'b1;
    end else if (do_clr) begin
      if (ccc_data[IBI_BIT]) ibi_q <= 1'b0;
      if (ccc_data[HJ_BIT])  hj_q  <= 1'b0;
    end
  end

  assign ibi_en = ibi_q;
  assign hj_en  = hj_q;
  assign cr_en  = 1'b0;

  always_comb begin
    evt_ctl          = 8'h00;
    evt_ctl[IBI_BIT] = ibi_q;
    evt_ctl[CR_BIT]  = cr_en;
    evt_ctl[HJ_BIT]  = hj_q;
  end

  assign ibi_go = ibi_req & ibi_q;
  assign hj_go  = hj_req  & hj_q;

  p_ibi_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && ccc_bcast && ccc_code == BC_ENABLE && ccc_data[IBI_BIT]) |=> ibi_en);
  p_ibi_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && ccc_bcast && ccc_code == BC_DISABLE && ccc_data[IBI_BIT]) |=> !ibi_en);
  p_hj_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && !ccc_bcast && ccc_dir_hit && ccc_code == DIR_ENABLE && ccc_data[HJ_BIT]) |=> hj_en);
  p_hj_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && !ccc_bcast && ccc_dir_hit && ccc_code == DIR_DISABLE && ccc_data[HJ_BIT]) |=> !hj_en);
  p_resv_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && !ccc_data[IBI_BIT] && !ccc_data[HJ_BIT] && (ccc_data[7:4] != 4'h0 || ccc_data[2:1] != 2'b00))
    |=> $stable(evt_ctl));
  p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && ccc_code != BC_ENABLE && ccc_code != BC_DISABLE &&
     ccc_code != DIR_ENABLE && ccc_code != DIR_DISABLE) |=> $stable(evt_ctl));
  p_dir_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && !ccc_bcast && !ccc_dir_hit) |=> $stable(evt_ctl));
  p_form_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ccc_valid && ccc_bcast && (ccc_code == DIR_ENABLE || ccc_code == DIR_DISABLE)) |=> $stable(evt_ctl));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ccc_valid |=> $stable(evt_ctl));
  p_gate_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ctl[HJ_BIT] |-> !hj_go);

endmodule

// File: tb/test_evt_enable_ctl.sv
`timescale 1ns/1ps
module test_evt_enable_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ccc_valid = 1'b0;
  logic [7:0] ccc_code = 8'h00;
  logic       ccc_bcast = 1'b0;
  logic       ccc_dir_hit = 1'b0;
  logic [7:0] ccc_data = 8'h00;
  logic       ibi_req = 1'b0;
  logic       hj_req = 1'b0;
  logic       ibi_en, hj_en, cr_en, ibi_go, hj_go;
  logic [7:0] evt_ctl;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit m_ibi = 1'b1;
  bit m_hj = 1'b1;

  always #2 clk = ~clk;

  evt_enable_ctl i_evt_enable_ctl (
    .clk(clk), .rst_n(rst_n), .ccc_valid(ccc_valid), .ccc_code(ccc_code),
    .ccc_bcast(ccc_bcast), .ccc_dir_hit(ccc_dir_hit), .ccc_data(ccc_data),
    .ibi_req(ibi_req), .hj_req(hj_req), .ibi_en(ibi_en), .hj_en(hj_en),
    .cr_en(cr_en), .evt_ctl(evt_ctl), .ibi_go(ibi_go), .hj_go(hj_go));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_state();
    check(tag, evt_ctl, {4'h0, m_hj, 2'b00, m_ibi});
    check("R2", {7'd0, ibi_en}, {7'd0, m_ibi});
    check("R3", {7'd0, hj_en}, {7'd0, m_hj});
    check("R5", {7'd0, cr_en}, 8'h00);
    check("R11", {evt_ctl[7:4], evt_ctl[2:1]}, 8'h00);
  endtask

  // Behavioural model: decide what the command means, then apply it.
  task automatic model_apply(input bit v, input logic [7:0] code, input bit bc,
                             input bit hit, input logic [7:0] d);
    int kind;
    kind = 0;
    if (v) begin
      case (code)
        8'h00: if (bc) kind = 1;
        8'h01: if (bc) kind = 2;
        8'h80: if (!bc && hit) kind = 1;
        8'h81: if (!bc && hit) kind = 2;
        default: kind = 0;
      endcase
    end
    if (kind == 1) begin
      if (d[0]) m_ibi = 1'b1;
      if (d[3]) m_hj = 1'b1;
    end else if (kind == 2) begin
      if (d[0]) m_ibi = 1'b0;
      if (d[3]) m_hj = 1'b0;
    end
  endtask

  task automatic step(input bit v, input logic [7:0] code, input bit bc, input bit hit,
                      input logic [7:0] d, input bit ir, input bit hr);
    @(negedge clk);
    ccc_valid = v; ccc_code = code; ccc_bcast = bc; ccc_dir_hit = hit; ccc_data = d;
    ibi_req = ir; hj_req = hr;
    #0.5;
    check("R9", {6'd0, hj_go, ibi_go}, {6'd0, hr & m_hj, ir & m_ibi});
    @(posedge clk);
    model_apply(v, code, bc, hit, d);
    #1;
    compare_state();
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    check("R1", evt_ctl, 8'h09);
    check("R1", {6'd0, hj_en, ibi_en}, 8'h03);
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R2"; // broadcast clear then set of the interrupt enable
    step(1, 8'h01, 1, 0, 8'h01, 1, 1);
    step(0, 8'h00, 0, 0, 8'h00, 1, 1);
    step(1, 8'h00, 1, 1, 8'h01, 1, 0);
    tag = "R3"; // direct clear then set of hot-join
    step(1, 8'h81, 0, 1, 8'h08, 0, 1);
    step(0, 8'h00, 0, 0, 8'h00, 1, 1);
    step(1, 8'h80, 0, 1, 8'h08, 0, 1);
    step(1, 8'h81, 0, 1, 8'h09, 1, 1);
    tag = "R4"; // zero and reserved bits leave state alone
    step(1, 8'h00, 1, 0, 8'h00, 1, 1);
    step(1, 8'h00, 1, 0, 8'hF4, 1, 1);
    step(1, 8'h80, 0, 1, 8'hF6, 1, 1);
    tag = "R5";
    step(1, 8'h00, 1, 0, 8'h02, 0, 0);
    step(1, 8'h01, 1, 0, 8'h02, 0, 0);
    step(1, 8'h00, 1, 0, 8'h08, 1, 1);
    step(1, 8'h81, 0, 1, 8'h03, 1, 1);
    tag = "R6"; // neighbouring codes do nothing
    step(1, 8'h02, 1, 1, 8'hFF, 1, 1);
    step(1, 8'h40, 1, 1, 8'hFF, 1, 1);
    step(1, 8'h82, 0, 1, 8'hFF, 1, 1);
    step(1, 8'hFF, 0, 1, 8'hFF, 1, 1);
    tag = "R7";
    step(1, 8'h80, 0, 0, 8'h09, 1, 1);
    step(1, 8'h00, 1, 0, 8'h01, 1, 1);
    step(1, 8'h81, 0, 0, 8'h09, 1, 1);
    tag = "R8";
    step(1, 8'h01, 0, 1, 8'h09, 1, 1);
    step(1, 8'h81, 1, 1, 8'h09, 1, 1);
    step(1, 8'h00, 0, 1, 8'h08, 1, 1);
    tag = "R10";
    step(0, 8'h01, 1, 1, 8'h09, 1, 1);
    step(0, 8'h81, 0, 1, 8'h09, 0, 1);
    tag = "R9";
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 8'h00, i[0], i[1]);

    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] c;
      int s;
      s = $urandom_range(0, 9);
      case (s)
        0: c = 8'h00; 1: c = 8'h01; 2: c = 8'h80; 3: c = 8'h81;
        4: c = 8'h00; 5: c = 8'h81; 6: c = 8'h01; 7: c = 8'h80;
        8: c = 8'h7F;
        default: c = 8'($urandom);
      endcase
      step(1'($urandom), c, 1'($urandom), 1'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule